// File: doc/BRIEF.md
# MSI Event Queue Engine

This block takes message-signalled interrupt writes arriving from the link side and sorts each one into one of several ring-buffer event queues kept in an internal record RAM. The low bits of the MSI data word select a vector. The vector's routing entry names the target queue and carries a pending flag. When the vector is routed and its queue is active, the engine writes a two-word record at the queue's tail, advances the tail and marks the vector pending. While the flag is set, further messages on that vector are discarded.

Software reaches every piece of state through one flat register port. It maps vectors to queues, enables and disables queues, moves the head pointer after it consumes records, clears the pending flags and reads records back. Each queue drives its own interrupt line, which stays high while the queue holds unconsumed records.

Top module: `msiq_engine`

## Requirements
- R1: After reset every vector entry is invalid and not pending, every queue has head 0, tail 0 and overflow 0, every queue state reads 1 (idle), and all interrupt lines are low.
- R2: reg_addr[15:12] selects a region and reg_addr[11:0] holds the index. The regions are 0 vector map, 1 vector clear, 2 queue control-set, 3 queue control-clear, 4 queue state, 5 queue tail, 6 queue head, 7 record. In the vector map, bit 63 is the valid bit and is writable. Bit 62 is the pending flag and is read-only. Bits 5:0 are the target queue number and are writable.
- R3: An accepted MSI stores its record at slot tail of the target queue and increments the 7-bit tail, which wraps from 127 to 0.
- R4: Record word 0 is laid out as follows. Bit 63 is 0. Bits 62:56 hold the type code followed by 3'b000, with type 0xF for a 64-bit address and 0xB for a 32-bit address. Bits 55:46 hold the length, bits 45:32 hold address bits 15:2, bits 31:16 hold the requester ID, and bits 15:0 hold the MSI data. Record word 1 holds address bits 63:16 in bits 63:16, and bits 15:0 are 0.
- R5: An accepted MSI sets the pending flag of its vector in the same cycle that the tail advances. MSIs on a pending vector are dropped. Writing a word with bit 62 set to the vector's clear register resets the flag.
- R6: An MSI is dropped with no state change when its vector is not below NUM_VEC, when its entry is invalid, when its queue number is not below NUM_Q, or when the target queue is not active.
- R7: When an accepted MSI finds tail+1 equal to head, nothing is written. The tail stays where it is, the overflow bit (bit 57 of the tail register) is set, the state becomes 4 (error), and the vector does not become pending.
- R8: Control-set bit 44 moves an idle queue to active. In control-clear, bit 44 moves an active queue to idle, bit 57 clears the overflow bit, and bit 47 moves an error queue to idle.
- R9: A queue's interrupt line is high exactly when its state is not idle and its head differs from its tail.
- R10: The head register holds its pointer in bits 6:0. A write stores the pointer and a read returns it.
- R11: A read of region 7 with index {queue, slot, word} returns that record word. The word number sits in bit 0, the 7-bit slot in bits 7:1 and the queue number in the bits above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | An MSI write is presented this cycle |
| msi_is64 | input | 1 | The MSI used a 64-bit address |
| msi_data | input | 16 | MSI data; the low bits give the vector |
| msi_rid | input | 16 | Requester ID |
| msi_addr | input | 64 | MSI target address |
| msi_len | input | 10 | Payload length field |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Region and index |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational read data for reg_addr |
| irq | output | NUM_Q | Per-queue interrupt lines |

## Verification
Overflow is the hardest condition to reach from the ports. The tail has to come around to one slot behind the head, which takes more than a hundred accepted messages, and every one of those vectors has to be cleared between sends or the pending flag drops the next message. The bench drives a single vector through a loop of send and clear steps, moves the head part-way through the ring, and keeps going past the wrap until the ring is full. It then walks the queue through overflow clear, error-to-idle and re-enable.

// File: rtl/msiq_pkg.sv
package msiq_pkg;

   typedef enum logic [2:0] {
      QS_IDLE   = 3'b001,
      QS_ACTIVE = 3'b010,
      QS_ERROR  = 3'b100
   } qstate_e;

   localparam logic [3:0] RG_MAP   = 4'h0;
   localparam logic [3:0] RG_VCLR  = 4'h1;
   localparam logic [3:0] RG_QSET  = 4'h2;
   localparam logic [3:0] RG_QCLR  = 4'h3;
   localparam logic [3:0] RG_STATE = 4'h4;
   localparam logic [3:0] RG_TAIL  = 4'h5;
   localparam logic [3:0] RG_HEAD  = 4'h6;
   localparam logic [3:0] RG_REC   = 4'h7;

   localparam int B_VALID = 63;
   localparam int B_PEND  = 62;
   localparam int B_OVF   = 57;
   localparam int B_E2I   = 47;
   localparam int B_EN    = 44;

   localparam logic [3:0] TY_MSI32 = 4'hB;
   localparam logic [3:0] TY_MSI64 = 4'hF;

   function automatic logic [63:0] rec_word0(input logic is64, input logic [9:0] len,
                                             input logic [63:0] addr, input logic [15:0] rid,
                                             input logic [15:0] data);
      logic [3:0] ty;
      ty = is64 ? TY_MSI64 : TY_MSI32;
      return {1'b0, ty, 3'b000, len, addr[15:2], rid, data};
   endfunction

   function automatic logic [63:0] rec_word1(input logic [63:0] addr);
      return {addr[63:16], 16'h0000};
   endfunction

endpackage

// File: rtl/msiq_vec_table.sv
module msiq_vec_table
   import msiq_pkg::*;
#(
   parameter int NUM_VEC = 16,
   parameter int QNUM_W  = 6,
   localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              map_we,
   input  logic              clr_we,
   input  logic [VEC_W-1:0]  sw_idx,
   input  logic [63:0]       sw_wdata,
   input  logic [VEC_W-1:0]  lk_idx,
   output logic              lk_valid,
   output logic              lk_pend,
   output logic [QNUM_W-1:0] lk_qnum,
   input  logic              set_pend,
   output logic [63:0]       rd_word
);

   logic              valid_q [NUM_VEC];
   logic              pend_q  [NUM_VEC];
   logic [QNUM_W-1:0] qnum_q  [NUM_VEC];

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
      logic hit_sw;
      logic hit_lk;
      assign hit_sw = (sw_idx == VEC_W'(v));
      assign hit_lk = (lk_idx == VEC_W'(v));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[v] <= 1'b0;
            qnum_q[v]  <= '0;
         end else if (map_we && hit_sw) begin
            valid_q[v] <= sw_wdata[B_VALID];
            qnum_q[v]  <= sw_wdata[QNUM_W-1:0];
         end
      end

      // enqueue setting wins over a software clear in the same cycle
      always_ff @(posedge clk) begin
         if (!rst_n)
            pend_q[v] <= 1'b0;
         else if (set_pend && hit_lk)
            pend_q[v] <= 1'b1;
         else if (clr_we && hit_sw && sw_wdata[B_PEND])
            pend_q[v] <= 1'b0;
      end
   end

   always_comb begin
      lk_valid = valid_q[lk_idx];
      lk_pend  = pend_q[lk_idx];
      lk_qnum  = qnum_q[lk_idx];
      rd_word  = '0;
      rd_word[B_VALID]    = valid_q[sw_idx];
      rd_word[B_PEND]     = pend_q[sw_idx];
      rd_word[QNUM_W-1:0] = qnum_q[sw_idx];
   end

   // R5: a vector that was just accepted reads pending on the next cycle
   p_pend_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_pend |=> pend_q[$past(lk_idx)]);

endmodule

// File: rtl/msiq_queue_ctl.sv
module msiq_queue_ctl
   import msiq_pkg::*;
#(
   parameter int PTR_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic             head_we,
   input  logic [63:0]      wdata,
   input  logic             enq_req,
   output logic             enq_ok,
   output logic [PTR_W-1:0] tail,
   output logic [PTR_W-1:0] head,
   output logic             ovf,
   output qstate_e          state,
   output logic             irq
);

   qstate_e state_nx;
   logic    full;
   logic    ovf_evt;

   assign full    = (PTR_W'(tail + 1'b1) == head);
   assign enq_ok  = enq_req && (state == QS_ACTIVE) && !full;
   assign ovf_evt = enq_req && (state == QS_ACTIVE) && full;
   assign irq     = (state != QS_IDLE) && (head != tail);

   always_comb begin
      state_nx = state;
      if (ovf_evt) state_nx = QS_ERROR;
      if (set_we && wdata[B_EN] && state == QS_IDLE) state_nx = QS_ACTIVE;
      if (clr_we) begin
         if (wdata[B_EN] && state == QS_ACTIVE) state_nx = QS_IDLE;
         if (wdata[B_E2I] && state == QS_ERROR) state_nx = QS_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= QS_IDLE;
         head  <= '0;
         tail  <= '0;
         ovf   <= 1'b0;
      end else begin
         state <= state_nx;
         if (head_we) head <= wdata[PTR_W-1:0];
         if (enq_ok) tail <= tail + 1'b1;
         if (clr_we && wdata[B_OVF]) ovf <= 1'b0;
         else if (ovf_evt) ovf <= 1'b1;
      end
   end

   // R3: an accepted record advances the tail by exactly one, modulo the ring
   p_tail_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      enq_ok |=> tail == PTR_W'($past(tail) + 1'b1));

   // R7: a full ring keeps its tail
   p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_req && full) |=> tail == $past(tail));

   // R7: a freshly latched overflow comes with the error state
   p_ovf_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ovf) && !$past(clr_we)) |-> state == QS_ERROR);

   // R1 / R8: state stays one-hot
   p_state_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state) == 1);

endmodule

// File: rtl/msiq_record_ram.sv
module msiq_record_ram #(
   parameter int AW    = 9,
   parameter int WIDTH = 128,
   localparam int DEPTH = 1 << AW
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/msiq_engine.sv
module msiq_engine
   import msiq_pkg::*;
#(
   parameter int NUM_VEC = 16,
   parameter int NUM_Q   = 4,
   parameter int PTR_W   = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             msi_valid,
   input  logic             msi_is64,
   input  logic [15:0]      msi_data,
   input  logic [15:0]      msi_rid,
   input  logic [63:0]      msi_addr,
   input  logic [9:0]       msi_len,
   input  logic             reg_wr,
   input  logic [15:0]      reg_addr,
   input  logic [63:0]      reg_wdata,
   output logic [63:0]      reg_rdata,
   output logic [NUM_Q-1:0] irq
);

   localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
   localparam int QW     = $clog2(NUM_Q);
   localparam int QNUM_W = 6;
   localparam int RAM_AW = QW + PTR_W;

   if (NUM_Q < 2 || NUM_Q > 64 || (NUM_Q & (NUM_Q - 1)) != 0) begin : g_chk_q
      $error("NUM_Q must be a power of two from 2 to 64");
   end
   if (NUM_VEC < 2 || NUM_VEC > 4096) begin : g_chk_v
      $error("NUM_VEC must be 2..4096");
   end
   if (PTR_W < 2 || PTR_W > 7 || RAM_AW + 1 > 12) begin : g_chk_p
      $error("PTR_W must be 2..7 and the record index must fit 12 bits");
   end

   logic [3:0]  region;
   logic [11:0] idx;
   assign region = reg_addr[15:12];
   assign idx    = reg_addr[11:0];

   logic sw_vec_ok, sw_q_ok;
   assign sw_vec_ok = (idx < 12'(NUM_VEC));
   assign sw_q_ok   = (idx < 12'(NUM_Q));

   // vector table
   logic              lk_valid, lk_pend, vec_in, q_in, route, ram_we;
   logic [QNUM_W-1:0] lk_qnum;
   logic [63:0]       map_word;

   assign vec_in = (msi_data < 16'(NUM_VEC));

   msiq_vec_table #(.NUM_VEC(NUM_VEC), .QNUM_W(QNUM_W)) u_vec (
      .clk      (clk),
      .rst_n    (rst_n),
      .map_we   (reg_wr && region == RG_MAP && sw_vec_ok),
      .clr_we   (reg_wr && region == RG_VCLR && sw_vec_ok),
      .sw_idx   (idx[VEC_W-1:0]),
      .sw_wdata (reg_wdata),
      .lk_idx   (msi_data[VEC_W-1:0]),
      .lk_valid (lk_valid),
      .lk_pend  (lk_pend),
      .lk_qnum  (lk_qnum),
      .set_pend (ram_we),
      .rd_word  (map_word)
   );

   assign q_in  = (lk_qnum < QNUM_W'(NUM_Q));
   assign route = msi_valid && vec_in && lk_valid && !lk_pend && q_in;

   // queues
   logic [NUM_Q-1:0] enq_ok;
   logic [NUM_Q-1:0] ovf_arr;
   logic [PTR_W-1:0] tail_arr [NUM_Q];
   logic [PTR_W-1:0] head_arr [NUM_Q];
   qstate_e          state_arr [NUM_Q];

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      logic hit;
      assign hit = sw_q_ok && (idx[QW-1:0] == QW'(q));
      msiq_queue_ctl #(.PTR_W(PTR_W)) u_ctl (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_we  (reg_wr && region == RG_QSET && hit),
         .clr_we  (reg_wr && region == RG_QCLR && hit),
         .head_we (reg_wr && region == RG_HEAD && hit),
         .wdata   (reg_wdata),
         .enq_req (route && lk_qnum == QNUM_W'(q)),
         .enq_ok  (enq_ok[q]),
         .tail    (tail_arr[q]),
         .head    (head_arr[q]),
         .ovf     (ovf_arr[q]),
         .state   (state_arr[q]),
         .irq     (irq[q])
      );
   end

   // record store
   logic [QW-1:0]     tq;
   logic [RAM_AW-1:0] waddr, raddr;
   logic [127:0]      rec_wdata, rec_rdata;

   assign tq        = lk_qnum[QW-1:0];
   assign ram_we    = |enq_ok;
   assign waddr     = {tq, tail_arr[tq]};
   assign rec_wdata = {rec_word1(msi_addr),
                       rec_word0(msi_is64, msi_len, msi_addr, msi_rid, msi_data)};
   assign raddr     = idx[RAM_AW:1];

   msiq_record_ram #(.AW(RAM_AW), .WIDTH(128)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (waddr),
      .wdata (rec_wdata),
      .raddr (raddr),
      .rdata (rec_rdata)
   );

   // register read mux
   logic [QW-1:0] rq;
   assign rq = idx[QW-1:0];

   always_comb begin
      reg_rdata = '0;
      unique case (region)
         RG_MAP:   if (sw_vec_ok) reg_rdata = map_word;
         RG_STATE: if (sw_q_ok) reg_rdata[2:0] = state_arr[rq];
         RG_TAIL:  if (sw_q_ok) begin
                      reg_rdata[PTR_W-1:0] = tail_arr[rq];
                      reg_rdata[B_OVF]     = ovf_arr[rq];
                   end
         RG_HEAD:  if (sw_q_ok) reg_rdata[PTR_W-1:0] = head_arr[rq];
         RG_REC:   reg_rdata = idx[0] ? rec_rdata[127:64] : rec_rdata[63:0];
         default:  reg_rdata = '0;
      endcase
   end

   // R5 / R6: nothing is written for a pending, invalid or out-of-range vector
   p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_valid && (!vec_in || !lk_valid || lk_pend)) |-> !ram_we);

   // R3: at most one queue accepts per cycle
   p_one_enq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(enq_ok));

   // R9: an idle-free, non-empty queue is the only source of an interrupt
   p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_arr[0] == QS_IDLE) || (head_arr[0] == tail_arr[0])) |-> !irq[0]);

endmodule

// File: tb/sim_msiq_engine.sv
module sim_msiq_engine;

   localparam int NQ = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          msi_valid = 1'b0;
   logic          msi_is64 = 1'b0;
   logic [15:0]   msi_data = '0;
   logic [15:0]   msi_rid = '0;
   logic [63:0]   msi_addr = '0;
   logic [9:0]    msi_len = '0;
   logic          reg_wr = 1'b0;
   logic [15:0]   reg_addr = '0;
   logic [63:0]   reg_wdata = '0;
   logic [63:0]   reg_rdata;
   logic [NQ-1:0] irq;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   msiq_engine #(.NUM_VEC(16), .NUM_Q(NQ), .PTR_W(7)) u0 (
      .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_is64(msi_is64),
      .msi_data(msi_data), .msi_rid(msi_rid), .msi_addr(msi_addr), .msi_len(msi_len),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   localparam logic [63:0] BV  = 64'h1 << 63;
   localparam logic [63:0] BP  = 64'h1 << 62;
   localparam logic [63:0] BO  = 64'h1 << 57;
   localparam logic [63:0] BE2 = 64'h1 << 47;
   localparam logic [63:0] BEN = 64'h1 << 44;

   function automatic logic [15:0] ad(input logic [3:0] rg, input int ix);
      return {rg, 12'(ix)};
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [63:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic send(input int vec, input logic is64, input logic [63:0] a,
                       input logic [15:0] rid, input logic [9:0] len);
      @(negedge clk);
      msi_valid = 1'b1; msi_data = 16'(vec); msi_is64 = is64;
      msi_addr = a; msi_rid = rid; msi_len = len;
      @(negedge clk);
      msi_valid = 1'b0;
   endtask

   function automatic logic [63:0] w0(input logic is64, input logic [9:0] len,
                                      input logic [63:0] a, input logic [15:0] rid,
                                      input logic [15:0] dat);
      return {1'b0, (is64 ? 4'hF : 4'hB), 3'b000, len, a[15:2], rid, dat};
   endfunction

   logic [63:0] r;

   task automatic t_reset;
      for (int q = 0; q < NQ; q++) begin
         rd(ad(4, q), r); chk("R1 state idle", r, 64'd1);
         rd(ad(5, q), r); chk("R1 tail/ovf", r, 64'd0);
         rd(ad(6, q), r); chk("R1 head", r, 64'd0);
      end
      rd(ad(0, 3), r); chk("R1 map cleared", r, 64'd0);
      chk("R1 irq low", 64'(irq), 64'd0);
   endtask

   task automatic t_map_enable;
      wr(ad(0, 3), BV | BP | 64'd1);
      rd(ad(0, 3), r); chk("R2 map readback, pending read-only", r, BV | 64'd1);
      wr(ad(2, 1), BEN);
      rd(ad(4, 1), r); chk("R8 enable -> active", r, 64'd2);
   endtask

   task automatic t_enqueue;
      logic [63:0] a;
      a = 64'h0000_0123_4567_89AC;
      send(3, 1'b1, a, 16'hBEEF, 10'd1);
      rd(ad(5, 1), r); chk("R3 tail advanced", r, 64'd1);
      chk("R9 irq while non-empty", 64'(irq[1]), 64'd1);
      rd(ad(0, 3), r); chk("R5 pending set", r, BV | BP | 64'd1);
      rd(ad(7, (1 << 8) | 0), r); chk("R4 R11 word0 64-bit", r, w0(1'b1, 10'd1, a, 16'hBEEF, 16'd3));
      rd(ad(7, (1 << 8) | 1), r); chk("R4 R11 word1", r, {a[63:16], 16'h0});
   endtask

   task automatic t_pending;
      logic [63:0] a;
      a = 64'h0000_0000_FEE0_1234;
      send(3, 1'b0, a, 16'h0042, 10'd2);
      rd(ad(5, 1), r); chk("R5 pending vector dropped", r, 64'd1);
      wr(ad(1, 3), BP);
      rd(ad(0, 3), r); chk("R5 clear resets pending", r, BV | 64'd1);
      send(3, 1'b0, a, 16'h0042, 10'd2);
      rd(ad(5, 1), r); chk("R5 accepted after clear", r, 64'd2);
      rd(ad(7, (1 << 8) | 2), r); chk("R4 word0 32-bit", r, w0(1'b0, 10'd2, a, 16'h0042, 16'd3));
   endtask

   task automatic t_drops;
      wr(ad(0, 6), BV | 64'd2);
      wr(ad(0, 7), BV | 64'd10);
      send(5, 1'b0, 64'h100, 16'h1, 10'd1);
      send(6, 1'b0, 64'h100, 16'h1, 10'd1);
      send(7, 1'b0, 64'h100, 16'h1, 10'd1);
      send(20, 1'b0, 64'h100, 16'h1, 10'd1);
      rd(ad(5, 2), r); chk("R6 disabled queue untouched", r, 64'd0);
      rd(ad(5, 1), r); chk("R6 queue1 unchanged", r, 64'd2);
      rd(ad(0, 6), r); chk("R6 no pending on drop", r, BV | 64'd2);
      rd(ad(0, 5), r); chk("R6 invalid vector no pending", r, 64'd0);
   endtask

   task automatic t_head_disable;
      wr(ad(6, 1), 64'd2);
      rd(ad(6, 1), r); chk("R10 head readback", r, 64'd2);
      chk("R9 irq low when empty", 64'(irq[1]), 64'd0);
      wr(ad(6, 1), 64'd1);
      chk("R9 irq high again", 64'(irq[1]), 64'd1);
      wr(ad(3, 1), BEN);
      rd(ad(4, 1), r); chk("R8 disable -> idle", r, 64'd1);
      chk("R9 irq low when idle", 64'(irq[1]), 64'd0);
   endtask

   task automatic t_wrap_overflow;
      wr(ad(0, 0), BV | 64'd0);
      wr(ad(2, 0), BEN);
      for (int i = 0; i < 127; i++) begin
         send(0, 1'b0, 64'h40 + 64'(i * 4), 16'h7, 10'd1);
         wr(ad(1, 0), BP);
      end
      rd(ad(5, 0), r); chk("R3 tail at 127", r, 64'd127);
      wr(ad(6, 0), 64'd100);
      send(0, 1'b0, 64'h3000, 16'h7, 10'd1);
      wr(ad(1, 0), BP);
      rd(ad(5, 0), r); chk("R3 tail wraps to 0", r, 64'd0);
      rd(ad(7, (127 << 1)), r); chk("R3 R11 last slot written", r, w0(1'b0, 10'd1, 64'h3000, 16'h7, 16'd0));
      for (int i = 0; i < 99; i++) begin
         send(0, 1'b0, 64'h80, 16'h7, 10'd1);
         wr(ad(1, 0), BP);
      end
      rd(ad(5, 0), r); chk("R3 tail at 99", r, 64'd99);
      rd(ad(7, (99 << 1)), r);
      send(0, 1'b1, 64'hFFFF_0000_0000_0000, 16'h9, 10'd3);
      rd(ad(5, 0), r); chk("R7 overflow latched, tail held", r, BO | 64'd99);
      rd(ad(4, 0), r); chk("R7 error state", r, 64'd4);
      rd(ad(0, 0), r); chk("R7 vector not pending", r, BV);
      chk("R9 irq in error", 64'(irq[0]), 64'd1);
      send(0, 1'b0, 64'h80, 16'h7, 10'd1);
      rd(ad(5, 0), r); chk("R7 error drops", r, BO | 64'd99);
      wr(ad(3, 0), BO);
      rd(ad(5, 0), r); chk("R8 overflow cleared", r, 64'd99);
      rd(ad(4, 0), r); chk("R8 still error", r, 64'd4);
      wr(ad(3, 0), BE2);
      rd(ad(4, 0), r); chk("R8 error -> idle", r, 64'd1);
      chk("R9 irq low after idle", 64'(irq[0]), 64'd0);
      wr(ad(2, 0), BEN);
      rd(ad(4, 0), r); chk("R8 re-enable", r, 64'd2);
      chk("R9 irq back", 64'(irq[0]), 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_map_enable();
      t_enqueue();
      t_pending();
      t_drops();
      t_head_disable();
      t_wrap_overflow();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule